// File: doc/BRIEF.md
# Select-Coded Integer ALU

This block is the combinational execute-stage arithmetic unit of a small 32-bit integer pipeline. Two data operands, an immediate shift count and a four-bit operation code come in. The same cycle, a data result and a flag that marks an all-zero result go out. The block has no clock and no state. The surrounding pipeline registers its inputs and outputs.

The operation code uses a fixed encoding that differs from the usual function-field layout. Decode logic upstream maps each instruction onto one of nine codes. The supported operations are:

- bitwise OR, AND and XOR;
- wrapping add and subtract;
- signed and unsigned set-on-less-than;
- logical shifts of the second operand by the shift-count input.

Every other code yields zero.

Top module: `sel_alu`

## Requirements
- R1: Code 4'b0000 drives `y` to `a | b`, code 4'b0110 to `a & b`, and code 4'b0101 to `a ^ b`.
- R2: Code 4'b0011 drives `y` to `a + b` modulo 2^32, with no exception or overflow output.
- R3: Code 4'b0100 drives `y` to `a - b` modulo 2^32.
- R4: Code 4'b0010 drives `y` to 1 when `a < b` as two's-complement signed values, and to 0 otherwise. Bits 31:1 are always zero.
- R5: Code 4'b0001 drives `y` to 1 when `a < b` as unsigned values, and to 0 otherwise. Bits 31:1 are always zero.
- R6: Code 4'b1111 drives `y` to `b` shifted left by `shamt` (0 to 31), with zeros filling the low bits.
- R7: Code 4'b1110 drives `y` to `b` shifted right by `shamt`, with zeros filling the high bits. Sign bits are not replicated.
- R8: Every code other than the nine above drives `y` to zero.
- R9: `zero` is 1 exactly when all 32 bits of `y` are 0.
- R10: Outputs depend only on the present inputs. There is no clocked state, and a change of input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand; the shifted value for shifts |
| shamt | input | 5 | Immediate shift count |
| op | input | 4 | Operation code |
| y | output | 32 | Result |
| zero | output | 1 | High when `y` is all zeros |

## Verification
Since the block holds no state, a faulty path shows at the ports in the same evaluation as the stimulus that exercises it. A wrong carry or borrow chain shows as a sum, difference or comparison that is off, most visibly at the sign and carry boundaries (0x7FFFFFFF, 0x80000000, all ones). A miswired shifter stage shows as a wrong result only for counts that have that stage's bit set. Sweeping every count from 0 to 31 therefore exposes each stage. A mis-decoded code shows as either a nonzero value on an unused code or a wrong operation on a valid one.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OR   = 4'b0000,
    OP_LTU  = 4'b0001,
    OP_LTS  = 4'b0010,
    OP_ADD  = 4'b0011,
    OP_SUB  = 4'b0100,
    OP_XOR  = 4'b0101,
    OP_AND  = 4'b0110,
    OP_SHR  = 4'b1110,
    OP_SHL  = 4'b1111
  } alu_op_e;
endpackage

// File: rtl/sel_alu_arith.sv
module sel_alu_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub_en,
  output logic [DATA_W-1:0] sum,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int unsigned EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] raw;
  logic [EXT_W-1:0] diff;

  // One adder for add; a separate subtract drives the comparisons.
  always_comb begin
    b_ext = {1'b0, b};
    raw   = {1'b0, a} + (sub_en ? (~b_ext + EXT_W'(1)) : b_ext);
    diff  = {1'b0, a} - b_ext;
  end

  assign sum         = raw[DATA_W-1:0];
  assign lt_unsigned = diff[DATA_W];
  assign lt_signed   = (a[DATA_W-1] != b[DATA_W-1]) ? a[DATA_W-1] : diff[DATA_W-1];
endmodule

// File: rtl/sel_alu_shift.sv
module sel_alu_shift #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               dir_left,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  assign stage[0] = din;

  // One stage per bit of the count; stage k moves by 2**k.
  generate
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int unsigned DIST = 1 << k;
      always_comb begin
        if (!amt[k]) begin
          stage[k+1] = stage[k];
        end else if (dir_left) begin
          stage[k+1] = {stage[k][DATA_W-1-DIST:0], {DIST{1'b0}}};
        end else begin
          stage[k+1] = {{DIST{1'b0}}, stage[k][DATA_W-1:DIST]};
        end
      end
    end
  endgenerate

  assign dout = stage[SHAMT_W];
endmodule

// File: rtl/sel_alu_zero.sv
module sel_alu_zero #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  output logic              is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [OP_W-1:0]    op,
  output logic [DATA_W-1:0]  y,
  output logic               zero
);
  logic [DATA_W-1:0] arith_q;
  logic [DATA_W-1:0] shift_q;
  logic              lts;
  logic              ltu;
  logic              is_sub;
  logic              is_left;

  assign is_sub  = (op == OP_SUB);
  assign is_left = (op == OP_SHL);

  sel_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a           (a),
    .b           (b),
    .sub_en      (is_sub),
    .sum         (arith_q),
    .lt_signed   (lts),
    .lt_unsigned (ltu)
  );

  sel_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din      (b),
    .amt      (shamt),
    .dir_left (is_left),
    .dout     (shift_q)
  );

  always_comb begin
    unique case (op)
      OP_OR:          y = a | b;
      OP_AND:         y = a & b;
      OP_XOR:         y = a ^ b;
      OP_ADD, OP_SUB: y = arith_q;
      OP_LTS:         y = DATA_W'(lts);
      OP_LTU:         y = DATA_W'(ltu);
      OP_SHL, OP_SHR: y = shift_q;
      default:        y = '0;
    endcase
  end

  sel_alu_zero #(.DATA_W(DATA_W)) u_zero (
    .val     (y),
    .is_zero (zero)
  );
endmodule

// File: rtl/sel_alu_chk.sv
module sel_alu_chk
  import sel_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  a,
  input logic [DATA_W-1:0]  b,
  input logic [SHAMT_W-1:0] shamt,
  input logic [OP_W-1:0]    op,
  input logic [DATA_W-1:0]  y,
  input logic               zero
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    AST_ZERO_FLAG: assert (zero == (y == '0)); // R9
    if (op == OP_ADD) begin
      AST_ADD_INVERT: assert (y - b == a); // R2
    end
    if (op == OP_SUB) begin
      AST_SUB_INVERT: assert (y + b == a); // R3
    end
    if (op == OP_LTS) begin
      AST_LTS_ONEBIT: assert ((y >> 1) == '0); // R4
    end
    if (op == OP_LTU) begin
      AST_LTU_ONEBIT: assert ((y >> 1) == '0); // R5
      AST_LTU_EQUAL: assert (!(a == b) || y == '0); // R5
    end
    if (op == OP_SHL && shamt != '0) begin
      AST_SHL_LSB_CLEAR: assert (y[0] == 1'b0); // R6
    end
    if (op == OP_SHR && shamt != '0) begin
      AST_SHR_MSB_CLEAR: assert (y[DATA_W-1] == 1'b0); // R7
    end
    if (!(op inside {OP_OR, OP_LTU, OP_LTS, OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_SHR, OP_SHL})) begin
      AST_UNUSED_ZERO: assert (y == '0 && zero); // R8
    end
    if (op == OP_OR) begin
      AST_OR_COVERS: assert ((y & a) == a && (y & b) == b && (y & ~(a | b)) == '0 && ONE != '0); // R1
    end
  end
endmodule

bind sel_alu sel_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .a     (a),
  .b     (b),
  .shamt (shamt),
  .op    (op),
  .y     (y),
  .zero  (zero)
);

// File: tb/sel_alu_tb_top.sv
module sel_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] a;
  logic [31:0] b;
  logic [4:0]  shamt;
  logic [3:0]  op;
  logic [31:0] y;
  logic        zero;
  int          n_cmp;
  int          n_bad;
  bit          done;

  sel_alu dut_i (
    .a     (a),
    .b     (b),
    .shamt (shamt),
    .op    (op),
    .y     (y),
    .zero  (zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] ma, input logic [31:0] mb,
                                        input logic [4:0] ms, input logic [3:0] mo);
    case (mo)
      4'b0000: return ma | mb;
      4'b0110: return ma & mb;
      4'b0101: return ma ^ mb;
      4'b0011: return ma + mb;
      4'b0100: return ma - mb;
      4'b0010: return ($signed(ma) < $signed(mb)) ? 32'd1 : 32'd0;
      4'b0001: return (ma < mb) ? 32'd1 : 32'd0;
      4'b1111: return mb << ms;
      4'b1110: return mb >> ms;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] mo);
    case (mo)
      4'b0000, 4'b0110, 4'b0101: return "R1";
      4'b0011: return "R2";
      4'b0100: return "R3";
      4'b0010: return "R4";
      4'b0001: return "R5";
      4'b1111: return "R6";
      4'b1110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] ta, input logic [31:0] tb,
                       input logic [4:0] ts, input logic [3:0] to);
    logic [31:0] exp;
    @(negedge clk);
    a = ta; b = tb; shamt = ts; op = to;
    #1;
    exp = model(ta, tb, ts, to);
    n_cmp++;
    if (y !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h s=%0d y=%h expected %h", req_of(to), to, ta, tb, ts, y, exp);
    end
    // R9: flag tracks the all-zero result
    n_cmp++;
    if (zero !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL R9 zero=%b expected %b", zero, (exp == 32'd0));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] corners [8];
    int unsigned seed_dummy;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    a = '0; b = '0; shamt = '0; op = '0;
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'hFFFF_FFFE;
    corners[6] = 32'h5555_AAAA; corners[7] = 32'h8000_0001;
    seed_dummy = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs give zero result and asserted flag (R10, R9)
    #1;
    n_cmp++;
    if (y !== 32'd0 || zero !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 y=%h zero=%b expected 0/1", y, zero);
    end
    // Directed corner operands across every code (R1..R8)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(corners[i], corners[j], 5'(i * 4 + j), 4'(o));
    // Shift count sweep on both directions (R6, R7)
    for (int s = 0; s < 32; s++) begin
      apply(32'd0, 32'hDEAD_BEEF, 5'(s), 4'b1111);
      apply(32'd0, 32'hDEAD_BEEF, 5'(s), 4'b1110);
      apply(32'd0, 32'h8000_0001, 5'(s), 4'b1110);
    end
    // Wrap cases (R2, R3)
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, 4'b0011);
    apply(32'd0, 32'd1, 5'd0, 4'b0100);
    // Same-cycle response to input change (R10)
    apply(32'd5, 32'd5, 5'd0, 4'b0100);
    apply(32'd5, 32'd4, 5'd0, 4'b0100);
    // Constrained random across valid and unused codes
    for (int k = 0; k < 4000; k++)
      apply($urandom, $urandom, 5'($urandom), 4'($urandom));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule